// File: doc/BRIEF.md
# Write-Once Protected Software Watchdog

This block pairs a software watchdog with a 16-bit protection control register that software may load only once per reset. The register selects whether the watchdog runs, whether its reference ticks pass through a divide-by-512 prescaler, and which of four power-of-two periods applies. Four further low bits are kept for a bus-monitor function that lives elsewhere; here they are only stored and read back.

Software keeps the watchdog alive by writing the key 0x55 and then the key 0xAA to a service address. If a full period of reference ticks passes without that ordered pair, the block raises a one-cycle timeout request and starts the next period on its own. A clock-mode strap input decides the prescaler bit's value out of reset: the bit takes the strap's inverse.

The bus side is a plain write strobe with a one-bit select (0 = control register, 1 = service address) and a continuously driven readback. Every write is accepted in the cycle its strobe is high, so there is no back-pressure and no handshake. The reference tick is a one-cycle enable in the `clk` domain.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_n` is low the register takes the value 0x0080 when `strap_clk_mode` is 1 and 0x00C0 when it is 0: bit 7 (enable) is 1, bit 6 (prescaler) is the inverse of the strap, bits 5..0 are 0.
- R2: Bits 15..8 of `ctl_rdata` always read 0, whatever value was written.
- R3: The first write with `bus_sel`=0 after reset loads `bus_wdata[7:0]` into the register; every later control write is ignored until the next reset.
- R4: Bits 3..0 are stored and read back and have no effect on the timeout period.
- R5: With bit 6 = 0, bits 5..4 codes 00, 01, 10 and 11 give periods of 2^9, 2^11, 2^13 and 2^15 reference ticks.
- R6: With bit 6 = 1, the period is 512 times longer (2^18 to 2^24 ticks); in particular no timeout occurs within 2^15 ticks for code 00.
- R7: A service write (`bus_sel`=1) of low byte 0x55 directly followed by a service write of 0xAA restarts the period; any other service order, such as 0xAA then 0x55, does not.
- R8: At the end of a period `wdt_timeout` is high for exactly one cycle and the next period starts from zero ticks, so timeouts repeat every period.
- R9: With bit 7 = 0 no timeout is ever produced and the tick count is held at zero.
- R10: After a restart, `wdt_timeout` is high in the cycle following the clock edge that takes the period's final tick, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_clk_mode | input | 1 | Clock-mode strap; its inverse becomes the prescaler bit in reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | 0 = control register, 1 = service address |
| bus_wdata | input | 16 | Write data |
| ctl_rdata | output | 16 | Control register readback |
| wdt_timeout | output | 1 | One-cycle timeout reset request |

## Verification
The assertions assume `rst_n` is held low for at least one clock edge before any check matters and that the strap is steady while reset is low; the bench keeps the strap fixed across each reset and releases reset only at a falling edge. They also take the tick count's reset to depend only on the enable and the service pair, so the bench drives `ref_tick` low while it issues writes, which keeps the tick count at each sampling point exactly as the requirements predict. The prescaled periods are too long to finish within the run, so the bench checks only their lower bound.

// File: rtl/wdt_guard_pkg.sv
`timescale 1ns/1ps
package wdt_guard_pkg;
  typedef struct packed {
    logic       run_en;
    logic       pre_sel;
    logic [1:0] period_sel;
    logic [1:0] bm_en;
    logic [1:0] bm_time;
  } prot_ctl_t;

  localparam logic SEL_CTL = 1'b0;
  localparam logic SEL_SVC = 1'b1;

  typedef enum logic { KEY_WAIT, KEY_HALF } key_state_t;
endpackage

// File: rtl/wdt_ctl_reg.sv
`timescale 1ns/1ps
module wdt_ctl_reg
  import wdt_guard_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              wr_en,
  input  logic [7:0]        wbyte,
  output prot_ctl_t         ctl,
  output logic              locked,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - $bits(prot_ctl_t);

  prot_ctl_t ctl_q;
  logic      lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q         <= '0;
      ctl_q.run_en  <= 1'b1;
      ctl_q.pre_sel <= ~strap;
      lock_q        <= 1'b0;
    end else if (wr_en && !lock_q) begin
      ctl_q  <= prot_ctl_t'(wbyte);
      lock_q <= 1'b1;
    end
  end

  assign ctl    = ctl_q;
  assign locked = lock_q;
  assign rdata  = {{PAD_W{1'b0}}, ctl_q};
endmodule

// File: rtl/wdt_key_seq.sv
`timescale 1ns/1ps
module wdt_key_seq
  import wdt_guard_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] key,
  output logic       restart
);
  key_state_t st_q;

  assign restart = wr_en && (st_q == KEY_HALF) && (key == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= KEY_WAIT;
    end else if (wr_en) begin
      st_q <= (key == KEY_FIRST) ? KEY_HALF : KEY_WAIT;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int PRE_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic bypass,
  input  logic clear,
  output logic tick_out
);
  generate
    if (PRE_W > 0) begin : g_div
      logic [PRE_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || clear || bypass) begin
          div_q <= '0;
        end else if (tick_in) begin
          div_q <= div_q + 1'b1;
        end
      end
      assign tick_out = bypass ? tick_in : (tick_in && (&div_q));
    end else begin : g_pass
      assign tick_out = tick_in;
    end
  endgenerate
endmodule

// File: rtl/wdt_period_ctr.sv
`timescale 1ns/1ps
module wdt_period_ctr #(
  parameter int BASE_EXP = 9,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [SEL_W-1:0] period_sel,
  output logic             timeout,
  output logic [BASE_EXP + 2*((2**SEL_W)-1) - 1:0] count
);
  localparam int MAX_SEL = (2**SEL_W) - 1;
  localparam int CNT_W   = BASE_EXP + 2*MAX_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             to_q;

  assign last_val = {CNT_W{1'b1}} >> (2*(MAX_SEL - int'(period_sel)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q >= last_val) begin
          cnt_q <= '0;
          to_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign timeout = to_q;
  assign count   = cnt_q;
endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         PRE_W      = 9,
  parameter int         BASE_EXP   = 9,
  parameter logic [7:0] KEY_FIRST  = 8'h55,
  parameter logic [7:0] KEY_SECOND = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_clk_mode,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              wdt_timeout
);
  localparam int CNT_W = BASE_EXP + 6;

  prot_ctl_t        ctl;
  logic             lock_q;
  logic             svc_restart;
  logic             ctr_clear;
  logic             slow_tick;
  logic [CNT_W-1:0] cnt_q;
  logic             wdata_hi_unused;

  assign wdata_hi_unused = ^bus_wdata[DATA_W-1:8];

  wdt_ctl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .strap  (strap_clk_mode),
    .wr_en  (bus_wr && (bus_sel == SEL_CTL)),
    .wbyte  (bus_wdata[7:0]),
    .ctl    (ctl),
    .locked (lock_q),
    .rdata  (ctl_rdata)
  );

  wdt_key_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && (bus_sel == SEL_SVC)),
    .key     (bus_wdata[7:0]),
    .restart (svc_restart)
  );

  assign ctr_clear = svc_restart || !ctl.run_en;

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (ref_tick),
    .bypass   (!ctl.pre_sel),
    .clear    (ctr_clear),
    .tick_out (slow_tick)
  );

  wdt_period_ctr #(.BASE_EXP(BASE_EXP), .SEL_W(2)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (slow_tick),
    .clear      (ctr_clear),
    .period_sel (ctl.period_sel),
    .timeout    (wdt_timeout),
    .count      (cnt_q)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
`timescale 1ns/1ps
module wdt_guard_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ctl_rdata,
  input logic              wdt_timeout,
  input logic              locked,
  input logic [CNT_W-1:0]  wd_count
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[DATA_W-1:8] == '0);

  // R3
  write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctl_rdata));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);

  // R9
  off_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> $past(ctl_rdata[7]));

  // R9
  off_count_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[7] |=> (wd_count == '0));
endmodule

bind wdt_guard wdt_guard_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_rdata   (ctl_rdata),
  .wdt_timeout (wdt_timeout),
  .locked      (lock_q),
  .wd_count    (cnt_q)
);

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        wdt_timeout;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdt_guard u0 (
    .clk(clk), .rst_n(rst_n), .strap_clk_mode(strap), .ref_tick(tick),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .ctl_rdata(ctl_rdata), .wdt_timeout(wdt_timeout)
  );

  // {first control write, second control write, expected readback}
  localparam logic [47:0] VEC [5] = '{
    {16'h0080, 16'h0000, 16'h0080},
    {16'hFF3C, 16'h0080, 16'h003C},
    {16'h00C5, 16'h00FF, 16'h00C5},
    {16'h1200, 16'h00AA, 16'h0000},
    {16'hAB7F, 16'h0001, 16'h007F}
  };

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(logic sel, logic [15:0] d);
    tick = 1'b0; bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // runs n ticks; timeout expected only after tick number at (0 = never)
  task automatic run_ticks(string req, int n, int at);
    int bad_k = -1;
    logic bad_v = 1'b0;
    tick = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (bad_k < 0 && wdt_timeout !== (k == at)) begin
        bad_k = k; bad_v = wdt_timeout;
      end
    end
    tick = 1'b0;
    checks++;
    if (bad_k >= 0) begin
      fails++;
      $display("FAIL %s: at tick %0d timeout actual %b expected %b", req, bad_k, bad_v, (bad_k == at));
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: bench hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset values follow the strap
    do_reset(1'b0);
    check16("R1 strap=0", ctl_rdata, 16'h00C0);
    do_reset(1'b1);
    check16("R1 strap=1", ctl_rdata, 16'h0080);

    // R3 R2: table of write-once vectors
    for (int i = 0; i < 5; i++) begin
      do_reset(1'b1);
      bus_write(1'b0, VEC[i][47:32]);
      bus_write(1'b0, VEC[i][31:16]);
      check16("R3 write-once", ctl_rdata, VEC[i][15:0]);
    end

    // R5 R10 shortest period, then R8 repeat
    do_reset(1'b1);
    bus_write(1'b0, 16'h0080);
    run_ticks("R10 first period 2^9", 512, 512);
    run_ticks("R8 repeat period", 512, 512);

    // R7 wrong order does not restart
    run_ticks("R7 mid period", 300, 0);
    bus_write(1'b1, 16'h00AA);
    bus_write(1'b1, 16'h0055);
    run_ticks("R7 wrong order ignored", 212, 212);

    // R7 correct pair restarts
    run_ticks("R7 before service", 300, 0);
    bus_write(1'b1, 16'h0055);
    bus_write(1'b1, 16'h00AA);
    run_ticks("R7 R10 after service", 512, 512);

    // R4 bus-monitor bits: no effect on period
    do_reset(1'b1);
    bus_write(1'b0, 16'h008F);
    check16("R4 readback", ctl_rdata, 16'h008F);
    run_ticks("R4 period unchanged", 512, 512);

    // R5 other codes
    do_reset(1'b1);
    bus_write(1'b0, 16'h0090);
    run_ticks("R5 code 01", 2048, 2048);
    do_reset(1'b1);
    bus_write(1'b0, 16'h00A0);
    run_ticks("R5 code 10", 8192, 8192);
    do_reset(1'b1);
    bus_write(1'b0, 16'h00B0);
    run_ticks("R5 code 11", 32768, 32768);

    // R6 prescaled: reset default with strap=0 is 0xC0
    do_reset(1'b0);
    run_ticks("R6 no early timeout", 32768, 0);

    // R9 disabled
    do_reset(1'b1);
    bus_write(1'b0, 16'h0000);
    run_ticks("R9 disabled 00", 2000, 0);
    do_reset(1'b1);
    bus_write(1'b0, 16'h0030);
    check16("R9 readback", ctl_rdata, 16'h0030);
    run_ticks("R9 disabled 11", 2000, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule